// File: doc/BRIEF.md
# Masked Composite-Field Column Mixer

This unit applies the AES column-mixing transform to one 32-bit column. Each byte arrives in the composite representation: a pair of 4-bit halves over GF(2^4). The unit never converts a byte back to the native byte field. Every column is protected by Boolean masking. The caller presents two shares: the masked data column and the column mask.

The transform is linear over XOR, so each share passes through its own identical copy of the mixing logic. The two shares never meet inside the unit.

The two fixed coefficients are replaced by composite constants:
- The constant two becomes `2y+6`.
- The constant three becomes `2y+7`.

Both are built from small nibble-level XOR networks. The two result shares are registered once and leave together with a valid flag. XORing the output shares gives the mixed image of the unmasked column. The output mask share is exactly the mixed image of the input mask. This lets the next stage go on tracking the mask.

Top module: `mc_comp_masked`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and both `col_o` and `mask_o` are all zero.
- R2: `out_valid_o` equals `in_valid_i` delayed by exactly one clock cycle. Results for a column presented with `in_valid_i` high appear on the outputs after the next rising edge.
- R3: Byte k of a column sits at bits `[31-8k -: 8]`. Within a byte, bits [7:4] hold the high half Sh and bits [3:0] hold the low half Sl, so the byte value is Sh·y + Sl. Nibble products reduce by x^4+x+1, and y^2 = y + 0xE. Output byte k equals 2·a[k] ^ 3·a[k+1] ^ a[k+2] ^ a[k+3], with indices taken mod 4. The constants two and three are written in composite form.
- R4: The composite constant for two is `2y+6` (byte 8'h26). A product by it has high half 4·Sh^2·Sl and low half 0xF·Sh^6·Sl.
- R5: The composite constant for three is `2y+7` (byte 8'h27). A product by it has high half 5·Sh^2·Sl and low half 0xF·Sh^7·Sl.
- R6: `col_o ^ mask_o` equals the composite-domain mix of `col_i ^ mask_i`. After mapping back to the native byte field, this matches the standard AES column mix of the unmasked column.
- R7: `mask_o` equals the composite-domain mix of `mask_i`.
- R8: A cycle with `in_valid_i` low leaves `col_o` and `mask_o` unchanged, whatever is on `col_i` and `mask_i`.
- R9: An all-zero share produces an all-zero result share. Equal shares produce equal result shares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input column valid |
| col_i | input | 32 | Masked data column, composite form |
| mask_i | input | 32 | Mask column, composite form |
| out_valid_o | output | 1 | Output column valid |
| col_o | output | 32 | Mixed masked data column |
| mask_o | output | 32 | Mixed mask column |

## Verification
The first group of stimulus is a set of known native-field columns with published mixing results:
- The uniform columns tell apart errors in the XOR of the two plain terms.
- The irregular columns expose byte-rotation mistakes.

The second group is random column/mask pairs. The bench maps each pair into the composite field with its own isomorphism, built from powers of `2y+6`. It then maps the result back and compares it against the native-field mix, which catches any wrong scaler constant.

The third group is single-byte columns. Each one isolates the two-scaler and the three-scaler in a known output lane.

Finally, hold, zero and equal-share cases separate enable and share-routing faults.

// File: rtl/mc_comp_pkg.sv
package mc_comp_pkg;

  localparam int unsigned NIB_W = 4;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic {
    SCALE_TWO   = 1'b0,
    SCALE_THREE = 1'b1
  } scale_e;

  // times x mod x^4+x+1
  function automatic nib_t nx2(input nib_t a);
    return {a[2], a[1], a[0] ^ a[3], a[3]};
  endfunction

  function automatic nib_t nx4(input nib_t a);
    return nx2(nx2(a));
  endfunction

  function automatic nib_t nx5(input nib_t a);
    return nx4(a) ^ a;
  endfunction

  function automatic nib_t nx6(input nib_t a);
    return nx4(a) ^ nx2(a);
  endfunction

  function automatic nib_t nx7(input nib_t a);
    return nx4(a) ^ nx2(a) ^ a;
  endfunction

  function automatic nib_t nxf(input nib_t a);
    return nx2(nx4(a)) ^ nx4(a) ^ nx2(a) ^ a;
  endfunction

endpackage

// File: rtl/mc_cf_scale.sv
module mc_cf_scale
  import mc_comp_pkg::*;
#(
  parameter scale_e MODE = SCALE_TWO
) (
  input  logic [2*NIB_W-1:0] byte_i,
  output logic [2*NIB_W-1:0] byte_o
);

  nib_t s_hi, s_lo, r_hi, r_lo;

  assign s_hi = byte_i[2*NIB_W-1:NIB_W];
  assign s_lo = byte_i[NIB_W-1:0];

  generate
    if (MODE == SCALE_TWO) begin : g_two
      // (2y+6)
      always_comb begin
        r_hi = nx4(s_hi) ^ nx2(s_lo);
        r_lo = nxf(s_hi) ^ nx6(s_lo);
      end
    end else begin : g_three
      // (2y+7)
      always_comb begin
        r_hi = nx5(s_hi) ^ nx2(s_lo);
        r_lo = nxf(s_hi) ^ nx7(s_lo);
      end
    end
  endgenerate

  assign byte_o = {r_hi, r_lo};

endmodule

// File: rtl/mc_cf_column.sv
module mc_cf_column
  import mc_comp_pkg::*;
#(
  parameter int unsigned BYTES = 4
) (
  input  logic [BYTES*2*NIB_W-1:0] col_i,
  output logic [BYTES*2*NIB_W-1:0] col_o
);

  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam int unsigned COL_W  = BYTES * BYTE_W;

  logic [BYTE_W-1:0] a   [BYTES];
  logic [BYTE_W-1:0] d2  [BYTES];
  logic [BYTE_W-1:0] t3  [BYTES];

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    localparam int unsigned K1 = (k + 1) % BYTES;
    localparam int unsigned K2 = (k + 2) % BYTES;
    localparam int unsigned K3 = (k + 3) % BYTES;

    assign a[k] = col_i[COL_W-1-k*BYTE_W -: BYTE_W];

    mc_cf_scale #(.MODE(SCALE_TWO)) i_two (
      .byte_i (a[k]),
      .byte_o (d2[k])
    );

    mc_cf_scale #(.MODE(SCALE_THREE)) i_three (
      .byte_i (a[k]),
      .byte_o (t3[k])
    );

    assign col_o[COL_W-1-k*BYTE_W -: BYTE_W] = d2[k] ^ t3[K1] ^ a[K2] ^ a[K3];
  end

endmodule

// File: rtl/mc_comp_masked.sv
module mc_comp_masked
  import mc_comp_pkg::*;
#(
  parameter int unsigned BYTES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [BYTES*2*NIB_W-1:0]   col_i,
  input  logic [BYTES*2*NIB_W-1:0]   mask_i,
  output logic                       out_valid_o,
  output logic [BYTES*2*NIB_W-1:0]   col_o,
  output logic [BYTES*2*NIB_W-1:0]   mask_o
);

  localparam int unsigned COL_W  = BYTES * 2 * NIB_W;
  localparam int unsigned SHARES = 2;

  logic [COL_W-1:0] sh_in  [SHARES];
  logic [COL_W-1:0] sh_mix [SHARES];
  logic [COL_W-1:0] sh_q   [SHARES];
  logic             vld_q;

  assign sh_in[0] = col_i;
  assign sh_in[1] = mask_i;

  // one independent datapath per share; shares never combine
  for (genvar s = 0; s < SHARES; s++) begin : g_share
    mc_cf_column #(.BYTES(BYTES)) i_col (
      .col_i (sh_in[s]),
      .col_o (sh_mix[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sh_q[s] <= '0;
      else if (in_valid_i) sh_q[s] <= sh_mix[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= in_valid_i;
  end

  assign out_valid_o = vld_q;
  assign col_o       = sh_q[0];
  assign mask_o      = sh_q[1];

endmodule

// File: rtl/mc_comp_masked_chk.sv
module mc_comp_masked_chk #(
  parameter int unsigned COL_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] mask_i,
  input logic             out_valid_o,
  input logic [COL_W-1:0] col_o,
  input logic [COL_W-1:0] mask_o
);

  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!out_valid_o && col_o == '0 && mask_o == '0); // R1
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    out_valid_o == $past(in_valid_i)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !$past(in_valid_i) |-> ($stable(col_o) && $stable(mask_o))); // R8

  AST_ZERO_SHARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && col_i == '0) |=> col_o == '0); // R9

  AST_EQUAL_SHARES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && col_i == mask_i) |=> col_o == mask_o); // R9

  AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_i == '0) |=> mask_o == '0); // R7

endmodule

bind mc_comp_masked mc_comp_masked_chk #(.COL_W(COL_W)) i_mc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .col_i       (col_i),
  .mask_i      (mask_i),
  .out_valid_o (out_valid_o),
  .col_o       (col_o),
  .mask_o      (mask_o)
);

// File: tb/test_mc_comp_masked.sv
module test_mc_comp_masked;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] col_i = '0;
  logic [31:0] mask_i = '0;
  logic        out_valid_o;
  logic [31:0] col_o;
  logic [31:0] mask_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mc_comp_masked i_mc_comp_masked (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .col_i       (col_i),
    .mask_i      (mask_i),
    .out_valid_o (out_valid_o),
    .col_o       (col_o),
    .mask_o      (mask_o)
  );

  // native column, mask, expected native mix
  localparam logic [95:0] VEC [6] = '{
    {32'hdb135345, 32'h3c5a11e7, 32'h8e4da1bc},
    {32'hf20a225c, 32'h00000000, 32'h9fdc589d},
    {32'h01010101, 32'hffffffff, 32'h01010101},
    {32'hc6c6c6c6, 32'h12345678, 32'hc6c6c6c6},
    {32'hd4d4d4d5, 32'ha5a5a5a5, 32'hd5d5d7d6},
    {32'h2d26314c, 32'h9e0170bd, 32'h4d7ebdf8}
  };

  logic [7:0] pw  [8];
  logic [7:0] inv [256];

  function automatic logic [3:0] g16(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p ^= 8'(a) << i;
    for (int i = 7; i >= 4; i--) if (p[i]) p ^= 8'h13 << (i - 4);
    return p[3:0];
  endfunction

  function automatic logic [7:0] cmul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh = g16(a[7:4], b[7:4]);
    logic [3:0] hi = hh ^ g16(a[7:4], b[3:0]) ^ g16(a[3:0], b[7:4]);
    logic [3:0] lo = g16(hh, 4'he) ^ g16(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] fwd(input logic [7:0] b);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (b[i]) r ^= pw[i];
    return r;
  endfunction

  function automatic logic [31:0] fwd_col(input logic [31:0] c);
    return {fwd(c[31:24]), fwd(c[23:16]), fwd(c[15:8]), fwd(c[7:0])};
  endfunction

  function automatic logic [31:0] inv_col(input logic [31:0] c);
    return {inv[c[31:24]], inv[c[23:16]], inv[c[15:8]], inv[c[7:0]]};
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [31:0] mix_native(input logic [31:0] c);
    logic [7:0] a [4];
    logic [31:0] r;
    for (int k = 0; k < 4; k++) a[k] = c[31-8*k -: 8];
    for (int k = 0; k < 4; k++)
      r[31-8*k -: 8] = xt(a[k]) ^ xt(a[(k+1)%4]) ^ a[(k+1)%4] ^ a[(k+2)%4] ^ a[(k+3)%4];
    return r;
  endfunction

  function automatic logic [31:0] mix_comp(input logic [31:0] c);
    logic [7:0] a [4];
    logic [31:0] r;
    for (int k = 0; k < 4; k++) a[k] = c[31-8*k -: 8];
    for (int k = 0; k < 4; k++)
      r[31-8*k -: 8] = cmul(a[k], 8'h26) ^ cmul(a[(k+1)%4], 8'h27) ^ a[(k+2)%4] ^ a[(k+3)%4];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] c, input logic [31:0] m);
    @(negedge clk_i);
    col_i = c;
    mask_i = m;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic full_check(input logic [31:0] xn, input logic [31:0] mn, input logic [31:0] expn);
    logic [31:0] xc = fwd_col(xn);
    logic [31:0] mc = fwd_col(mn);
    apply(xc ^ mc, mc);
    chk("R6", inv_col(col_o ^ mask_o), expn);
    chk("R7", mask_o, fwd_col(mix_native(mn)));
    chk("R3", col_o, mix_comp(xc ^ mc));
  endtask

  initial begin
    // composite images of native powers of two, built from 2y+6
    pw[0] = 8'h01;
    for (int i = 1; i < 8; i++) pw[i] = cmul(pw[i-1], 8'h26);
    for (int i = 0; i < 256; i++) inv[fwd(8'(i))] = 8'(i);

    #1;
    chk("R1", {31'd0, out_valid_o}, 32'd0);
    chk("R1", col_o, 32'd0);
    chk("R1", mask_o, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < 6; v++) full_check(VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);

    for (int n = 0; n < 200; n++) begin
      logic [31:0] x = $urandom;
      logic [31:0] m = $urandom;
      full_check(x, m, mix_native(x));
    end

    // R2: valid one cycle later, not before
    @(negedge clk_i);
    col_i = 32'h11223344; mask_i = 32'h0; in_valid_i = 1'b1;
    chk("R2", {31'd0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R2", {31'd0, out_valid_o}, 32'd1);
    @(negedge clk_i);
    chk("R2", {31'd0, out_valid_o}, 32'd0);

    // R4 / R5: single nonzero byte in lane 0
    for (int b = 1; b < 256; b += 37) begin
      apply({8'(b), 24'h0}, 32'h0);
      chk("R4", {24'h0, col_o[31:24]}, {24'h0, cmul(8'(b), 8'h26)});
      chk("R5", {24'h0, col_o[7:0]}, {24'h0, cmul(8'(b), 8'h27)});
      chk("R3", {16'h0, col_o[23:8]}, {16'h0, 8'(b), 8'(b)});
    end

    // R8: idle cycles with changing inputs leave outputs alone
    apply(32'hcafe1234, 32'h5a5a0f0f);
    @(negedge clk_i);
    col_i = 32'hdeadbeef; mask_i = 32'h87654321;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8", col_o, mix_comp(32'hcafe1234));
    chk("R8", mask_o, mix_comp(32'h5a5a0f0f));

    // R9: zero and equal shares
    apply(32'h0, 32'h9c3e7a01);
    chk("R9", col_o, 32'h0);
    apply(32'h6b8d2e47, 32'h6b8d2e47);
    chk("R9", col_o ^ mask_o, 32'h0);

    // R1: reset in mid-run
    apply(32'h01234567, 32'h89abcdef);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", col_o | mask_o, 32'h0);
    chk("R1", {31'd0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule